// File: doc/BRIEF.md
# Latch-Style Variable-Duty PWM Generator

This block turns an N-bit duty word into a pulse-width-modulated waveform whose period is fixed at 2^N clock cycles. A free-running counter provides the timebase. An output flip-flop behaves as a set/clear latch. It is set when the counter wraps and cleared when the count matches the active duty value. Changing the duty word changes only the high time and never the period.

The duty word is double-buffered. The value on the input is copied into an internal register only in the cycle where the counter wraps. Software or upstream logic can therefore change the word at any time without producing a malformed period. A one-cycle period pulse marks the wrap so that external logic can align its updates. An enable input pauses the whole block in place.

Top module: `pwm_latch_gen`

## Requirements
- R1: While `syncRst` is high at a clock edge, the counter, the captured duty value and `pwmOut` are cleared. In the first cycle after release, `pwmOut` is 0 and `periodPulse` is 0.
- R2: With `runEn` held high, `periodPulse` is high for exactly one cycle in every 2^N cycles. The first pulse after reset release comes in the 2^N-th cycle, which is the cycle where the count equals 2^N-1.
- R3: For a captured duty value D, where 0 < D < 2^N, `pwmOut` is high for exactly D enabled cycles in the period that follows the pulse. The high cycles are one contiguous run that starts in the first cycle after the pulse.
- R4: A captured duty value of 0 keeps `pwmOut` low for the whole period. When set and clear fall in the same cycle, clear wins.
- R5: A captured duty value of 2^N-1 gives 2^N-1 high cycles and exactly one low cycle, in the last count of the period. A constant 100% output cannot be produced.
- R6: `dutyIn` is sampled only in a cycle where `periodPulse` is high. A change of `dutyIn` in the middle of a period leaves the high time of that period unchanged.
- R7: From reset release until the first `periodPulse`, `pwmOut` stays low whatever the value of `dutyIn`.
- R8: In a cycle where `runEn` is low, the counter and `pwmOut` keep their values and `periodPulse` is 0. High time is counted only over enabled cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| syncRst | input | 1 | Synchronous reset, active high |
| runEn | input | 1 | Advances the timebase when high; freezes the block when low |
| dutyIn | input | CNT_W | Requested number of high cycles per period |
| pwmOut | output | 1 | Registered PWM waveform |
| periodPulse | output | 1 | One-cycle strobe in the last count of each period |

## Verification
The duty values applied are 0, 1, 2, mid-scale, 2^N-2 and 2^N-1, and the sequence includes both a jump from full to zero and a jump from zero to full. These patterns separate an off-by-one in the comparator from a wrong priority between set and clear. They also catch a missing low cycle at the top of the range. A duty word rewritten partway through a period detects any path that lets the input bypass the shadow register. A pause of several dozen cycles while the output is high, and a reset while a period is running, test whether the high count and the period length survive interruption and whether the output stays silent until the first capture.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

  // Strobes handed from the period control to the duty datapath.
  typedef struct packed {
    logic advance;  // timebase moves forward this cycle
    logic wrap;     // last count of the period; load and set point
  } pwmStrobe_t;

endpackage

// File: rtl/pwm_period_ctrl.sv
module pwm_period_ctrl
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             syncRst,
  input  logic             runEn,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] cntNext,
  output pwmStrobe_t       strobe
);

  localparam logic [CNT_W-1:0] CNT_LAST = '1;
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  // Natural binary wrap from all-ones to zero.
  assign cntNext = cntQ + CNT_ONE;

  always_ff @(posedge clk) begin
    if (syncRst) begin
      cntQ <= '0;
    end else if (runEn) begin
      cntQ <= cntNext;
    end
  end

  always_comb begin
    strobe.advance = runEn;
    strobe.wrap    = runEn && (cntQ == CNT_LAST);
  end

  // R2: the period strobe never lasts two cycles
  assert_wrap_single_R2: assert property (@(posedge clk) disable iff (syncRst)
    strobe.wrap |=> !strobe.wrap);

  // R2: a new period starts at count zero
  assert_wrap_restart_R2: assert property (@(posedge clk) disable iff (syncRst)
    strobe.wrap |=> (cntQ == '0));

  // R8: a paused timebase holds its count
  assert_idle_count_R8: assert property (@(posedge clk) disable iff (syncRst)
    !runEn |=> $stable(cntQ));

endmodule

// File: rtl/pwm_duty_path.sv
module pwm_duty_path
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             syncRst,
  input  pwmStrobe_t       strobe,
  input  logic [CNT_W-1:0] cntNext,
  input  logic [CNT_W-1:0] dutyIn,
  output logic             pwmQ
);

  localparam logic [CNT_W-1:0] DUTY_FULL = '1;

  logic [CNT_W-1:0] dutyReg;
  logic [CNT_W-1:0] dutyNext;
  logic             matchHit;
  logic             setReq;

  // The value that governs the coming period: fresh at the wrap, held otherwise.
  assign dutyNext = strobe.wrap ? dutyIn : dutyReg;

  // Compare against the count the next cycle will show, so the
  // registered output drops exactly when that count reaches the duty value.
  assign matchHit = strobe.advance && (cntNext == dutyNext);
  assign setReq   = strobe.wrap;

  always_ff @(posedge clk) begin
    if (syncRst) begin
      dutyReg <= '0;
    end else if (strobe.wrap) begin
      dutyReg <= dutyIn;
    end
  end

  // Set/clear latch; clear takes priority.
  always_ff @(posedge clk) begin
    if (syncRst) begin
      pwmQ <= 1'b0;
    end else if (matchHit) begin
      pwmQ <= 1'b0;
    end else if (setReq) begin
      pwmQ <= 1'b1;
    end
  end

  // R4: zero duty captured at the wrap keeps the output low
  assert_zero_duty_low_R4: assert property (@(posedge clk) disable iff (syncRst)
    (strobe.wrap && (dutyIn == '0)) |=> !pwmQ);

  // R5: full-scale duty goes high at the start of the period
  assert_full_duty_high_R5: assert property (@(posedge clk) disable iff (syncRst)
    (strobe.wrap && (dutyIn == DUTY_FULL)) |=> pwmQ);

  // R3: the output only rises at a period boundary
  assert_rise_on_wrap_R3: assert property (@(posedge clk) disable iff (syncRst)
    $rose(pwmQ) |-> $past(strobe.wrap));

  // R6: the captured duty changes only at the wrap
  assert_duty_frozen_R6: assert property (@(posedge clk) disable iff (syncRst)
    !strobe.wrap |=> $stable(dutyReg));

  // R8: a paused block holds its output
  assert_idle_output_R8: assert property (@(posedge clk) disable iff (syncRst)
    !strobe.advance |=> $stable(pwmQ));

endmodule

// File: rtl/pwm_latch_gen.sv
module pwm_latch_gen
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             syncRst,
  input  logic             runEn,
  input  logic [CNT_W-1:0] dutyIn,
  output logic             pwmOut,
  output logic             periodPulse
);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;
  pwmStrobe_t       strobe;

  pwm_period_ctrl #(.CNT_W(CNT_W)) ctrlInst (
    .clk     (clk),
    .syncRst (syncRst),
    .runEn   (runEn),
    .cntQ    (cntQ),
    .cntNext (cntNext),
    .strobe  (strobe)
  );

  pwm_duty_path #(.CNT_W(CNT_W)) pathInst (
    .clk     (clk),
    .syncRst (syncRst),
    .strobe  (strobe),
    .cntNext (cntNext),
    .dutyIn  (dutyIn),
    .pwmQ    (pwmOut)
  );

  assign periodPulse = strobe.wrap;

  // R1: the output is low in the cycle after a reset edge
  assert_reset_quiet_R1: assert property (@(posedge clk)
    syncRst |=> !pwmOut);

  // R7: before the first wrap after reset the output stays low
  assert_first_period_low_R7: assert property (@(posedge clk) disable iff (syncRst)
    ($past(syncRst) && (cntQ == '0)) |-> !pwmOut);

endmodule

// File: tb/pwm_latch_gen_test.sv
module pwm_latch_gen_test;

  localparam int W   = 8;
  localparam int PER = 1 << W;

  logic         clk = 1'b0;
  logic         syncRst = 1'b1;
  logic         runEn = 1'b1;
  logic [W-1:0] dutyIn = '0;
  logic         pwmOut;
  logic         periodPulse;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 0;

  int    expQ[$];
  string tagQ[$];

  // monitor state
  int hiCnt = 0;
  int enCnt = 0;
  int rises = 0;
  int firstHigh = 0;
  logic prevPwm = 1'b0;

  always #2.5 clk = ~clk;

  pwm_latch_gen #(.CNT_W(W)) uut (
    .clk         (clk),
    .syncRst     (syncRst),
    .runEn       (runEn),
    .dutyIn      (dutyIn),
    .pwmOut      (pwmOut),
    .periodPulse (periodPulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: measures each period and compares it with the scoreboard.
  always @(negedge clk) begin
    if (syncRst) begin
      hiCnt = 0; enCnt = 0; rises = 0; firstHigh = 0; prevPwm = 1'b0;
    end else if (runEn) begin
      if (enCnt == 0) firstHigh = int'(pwmOut);
      else if (pwmOut && !prevPwm) rises++;
      hiCnt += int'(pwmOut);
      enCnt++;
      prevPwm = pwmOut;
      if (periodPulse) begin
        if (expQ.size() == 0) begin
          chk("R3 no expected period queued", 1, 0);
        end else begin
          int    e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk({t, " high cycles"}, hiCnt, e);
          chk({t, " starts high"}, firstHigh, (e > 0) ? 1 : 0);
          chk({t, " single run"}, rises, 0);
        end
        chk("R2 period length", enCnt, PER);
        hiCnt = 0; enCnt = 0; rises = 0; firstHigh = 0;
      end
    end
  end

  // Driver: sets the word for the period after the next wrap, pushes expectation.
  task automatic loadDuty(input int d, input string tag);
    dutyIn = d[W-1:0];
    do begin
      @(posedge clk); #1;
    end while (!periodPulse);
    expQ.push_back(d);
    tagQ.push_back(tag);
    @(posedge clk); #1;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    int pulses;
    dutyIn = 8'd77;
    waitCycles(3);
    syncRst = 1'b0;
    expQ.push_back(0); tagQ.push_back("R7");
    @(negedge clk);
    chk("R1 pwm after reset", int'(pwmOut), 0);
    chk("R1 pulse after reset", int'(periodPulse), 0);
    @(posedge clk); #1;

    loadDuty(77,  "R3");
    loadDuty(0,   "R4");
    loadDuty(1,   "R3");
    loadDuty(2,   "R3");
    loadDuty(254, "R5");
    loadDuty(255, "R5");
    loadDuty(0,   "R4");
    loadDuty(255, "R5");
    loadDuty(128, "R3");

    // R6: rewrite the word ten counts into a period of 30
    loadDuty(30, "R6");
    waitCycles(10);
    dutyIn = 8'd200;
    loadDuty(200, "R6");

    // R8: pause while the output is high
    loadDuty(50, "R8");
    waitCycles(10);
    begin
      logic held;
      held = pwmOut;
      chk("R8 output high before pause", int'(held), 1);
      runEn = 1'b0;
      pulses = 0;
      for (int i = 0; i < 30; i++) begin
        #0.5;
        if (pwmOut !== held) chk("R8 output held", int'(pwmOut), int'(held));
        pulses += int'(periodPulse);
        @(posedge clk); #1;
      end
      chk("R8 no pulse while paused", pulses, 0);
      chk("R8 output held at end of pause", int'(pwmOut), int'(held));
      runEn = 1'b1;
    end
    loadDuty(90, "R3");

    // R1/R7: reset in the middle of a running period
    waitCycles(20);
    syncRst = 1'b1;
    expQ.delete();
    tagQ.delete();
    waitCycles(2);
    syncRst = 1'b0;
    expQ.push_back(0); tagQ.push_back("R7");
    @(negedge clk);
    chk("R1 pwm after mid-run reset", int'(pwmOut), 0);
    chk("R1 pulse after mid-run reset", int'(periodPulse), 0);
    @(posedge clk); #1;

    loadDuty(60, "R3");
    loadDuty(0,  "R4");
    waitCycles(3);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule